// File: doc/BRIEF.md
# Pair-Partitioned Processor Allocator

This block hands out processors from a pool of sixteen, organised as eight adjacent even/odd pairs. A requester asks for either one processor or one adjacent pair. The block answers one cycle later with a success flag and the granted index. For a pair grant, the index is the even base of the pair. A release port returns a single processor or a whole pair to the free pool.

An eight-bit partition register is normally written once at initialization. Each bit decides the role of one pair. A pair with its bit set belongs to the single-request region. A pair with its bit clear is reserved for pair requests. Single grants can therefore never break up a reserved pair, so pair requests cannot fail because the free processors are scattered. Only one request is served per cycle. When both kinds arrive together, the pair request wins.

Top module: `pair_alloc`

## Requirements
- R1: After synchronous reset every processor is free, the partition register holds all ones (every pair in the single region), and `resp_vld` is 0.
- R2: A single request is answered in the cycle after it is presented (`resp_vld`=1, `resp_pair`=0). It grants the lowest-numbered free processor whose pair bit (bit `idx>>1`) is 1.
- R3: A single request never grants a processor whose pair bit is 0. If no eligible processor is free, the single request fails.
- R4: A pair request grants the lowest pair p whose bit is 0 and whose processors 2p and 2p+1 are both free. The response has `resp_pair`=1 and `resp_idx`=2p, which is always even.
- R5: A pair request never grants a pair whose bit is 1, nor a pair with one processor in use. If no such pair exists, the pair request fails.
- R6: A failed request returns `resp_ok`=0 and `resp_idx`=0 and leaves the free pool unchanged.
- R7: When a single and a pair request are presented in the same cycle, only the pair request is served. The single request is dropped and takes nothing.
- R8: A release (`rel_pair`=0: processor `rel_idx`; `rel_pair`=1: both processors of the pair containing `rel_idx`) makes them free from the next clock. A request in the same cycle as the release does not see them as free.
- R9: A partition write takes effect for requests from the next cycle. A request in the same cycle uses the previous value. The write does not change which processors are free.
- R10: A granted processor is not granted again until it has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| part_we | input | 1 | Partition register write enable |
| part_wdata | input | 8 | New partition value, one bit per pair (1 = single region) |
| sgl_req | input | 1 | Request one processor |
| pair_req | input | 1 | Request one adjacent even/odd pair |
| rel_vld | input | 1 | Release strobe |
| rel_pair | input | 1 | Release the whole pair containing `rel_idx` |
| rel_idx | input | 4 | Processor index being released |
| resp_vld | output | 1 | Response valid, one cycle after a request |
| resp_pair | output | 1 | Response belongs to a pair request |
| resp_ok | output | 1 | Grant succeeded |
| resp_idx | output | 4 | Granted processor, or pair base (0 on failure) |

## Verification
Three pairs of functions can fall in the same cycle. A single and a pair request can arrive together. A request can coincide with a release of a processor that would otherwise be the lowest candidate. A request can coincide with a partition write that would change its eligibility. The bench provokes each case deliberately. It judges the outcome against a cycle model that evaluates every request on the pool and partition as they stood before that clock edge. It then applies the grant, the release and the write afterwards. A sweep over all 256 partition values drains the pool with pair requests and then single requests, checking every grant and the final failure.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_SINGLE = 2'd1,
    REQ_PAIR   = 2'd2
  } req_kind_e;
endpackage

// File: rtl/alloc_first_set.sv
// Lowest-index set bit finder.
module alloc_first_set #(
  parameter int W = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/alloc_pair_scan.sv
// Finds the lowest reserved pair with both members free.
module alloc_pair_scan #(
  parameter int NUM_PAIRS = 8,
  localparam int NUM_PROCS = 2 * NUM_PAIRS,
  localparam int PAIR_W = $clog2(NUM_PAIRS)
) (
  input  logic [NUM_PROCS-1:0] free_map,
  input  logic [NUM_PAIRS-1:0] part,
  output logic                 found,
  output logic [PAIR_W-1:0]    pair_idx
);
  logic [NUM_PAIRS-1:0] cand;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign cand[p] = ~part[p] & free_map[2*p] & free_map[2*p+1];
  end

  alloc_first_set #(.W(NUM_PAIRS)) u_pick (
    .vec  (cand),
    .found(found),
    .idx  (pair_idx)
  );
endmodule

// File: rtl/alloc_single_scan.sv
// Finds the lowest free processor inside the single region.
module alloc_single_scan #(
  parameter int NUM_PAIRS = 8,
  localparam int NUM_PROCS = 2 * NUM_PAIRS,
  localparam int IDX_W = $clog2(NUM_PROCS)
) (
  input  logic [NUM_PROCS-1:0] free_map,
  input  logic [NUM_PAIRS-1:0] part,
  output logic                 found,
  output logic [IDX_W-1:0]     proc_idx
);
  logic [NUM_PROCS-1:0] cand;

  for (genvar i = 0; i < NUM_PROCS; i++) begin : g_proc
    assign cand[i] = free_map[i] & part[i/2];
  end

  alloc_first_set #(.W(NUM_PROCS)) u_pick (
    .vec  (cand),
    .found(found),
    .idx  (proc_idx)
  );
endmodule

// File: rtl/pair_alloc.sv
module pair_alloc #(
  parameter int NUM_PAIRS = 8,
  parameter logic [NUM_PAIRS-1:0] PART_RST = '1,
  localparam int NUM_PROCS = 2 * NUM_PAIRS,
  localparam int IDX_W = $clog2(NUM_PROCS),
  localparam int PAIR_W = IDX_W - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 part_we,
  input  logic [NUM_PAIRS-1:0] part_wdata,
  input  logic                 sgl_req,
  input  logic                 pair_req,
  input  logic                 rel_vld,
  input  logic                 rel_pair,
  input  logic [IDX_W-1:0]     rel_idx,
  output logic                 resp_vld,
  output logic                 resp_pair,
  output logic                 resp_ok,
  output logic [IDX_W-1:0]     resp_idx
);
  import alloc_pkg::*;

  logic [NUM_PAIRS-1:0] part_q;
  logic [NUM_PROCS-1:0] free_q;

  logic                 pr_found;
  logic [PAIR_W-1:0]    pr_idx;
  logic                 sg_found;
  logic [IDX_W-1:0]     sg_idx;

  req_kind_e            kind;
  logic [NUM_PROCS-1:0] take_mask;
  logic [NUM_PROCS-1:0] give_mask;
  logic                 grant_ok;
  logic [IDX_W-1:0]     grant_idx;

  alloc_pair_scan #(.NUM_PAIRS(NUM_PAIRS)) u_pair_scan (
    .free_map(free_q),
    .part    (part_q),
    .found   (pr_found),
    .pair_idx(pr_idx)
  );

  alloc_single_scan #(.NUM_PAIRS(NUM_PAIRS)) u_single_scan (
    .free_map(free_q),
    .part    (part_q),
    .found   (sg_found),
    .proc_idx(sg_idx)
  );

  // Request arbitration: a pair request outranks a single request.
  always_comb begin
    if (pair_req)     kind = REQ_PAIR;
    else if (sgl_req) kind = REQ_SINGLE;
    else              kind = REQ_NONE;
  end

  always_comb begin
    take_mask = '0;
    grant_ok  = 1'b0;
    grant_idx = '0;
    case (kind)
      REQ_PAIR: begin
        if (pr_found) begin
          grant_ok                  = 1'b1;
          grant_idx                 = {pr_idx, 1'b0};
          take_mask[{pr_idx, 1'b0}] = 1'b1;
          take_mask[{pr_idx, 1'b1}] = 1'b1;
        end
      end
      REQ_SINGLE: begin
        if (sg_found) begin
          grant_ok          = 1'b1;
          grant_idx         = sg_idx;
          take_mask[sg_idx] = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    give_mask = '0;
    if (rel_vld) begin
      if (rel_pair) begin
        give_mask[{rel_idx[IDX_W-1:1], 1'b0}] = 1'b1;
        give_mask[{rel_idx[IDX_W-1:1], 1'b1}] = 1'b1;
      end else begin
        give_mask[rel_idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      part_q <= PART_RST;
      free_q <= '1;
    end else begin
      if (part_we) part_q <= part_wdata;
      free_q <= (free_q & ~take_mask) | give_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_vld  <= 1'b0;
      resp_pair <= 1'b0;
      resp_ok   <= 1'b0;
      resp_idx  <= '0;
    end else begin
      resp_vld  <= (kind != REQ_NONE);
      resp_pair <= (kind == REQ_PAIR);
      resp_ok   <= grant_ok;
      resp_idx  <= grant_idx;
    end
  end
endmodule

// File: rtl/pair_alloc_chk.sv
module pair_alloc_chk #(
  parameter int NUM_PAIRS = 8,
  localparam int NUM_PROCS = 2 * NUM_PAIRS,
  localparam int IDX_W = $clog2(NUM_PROCS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_PAIRS-1:0] part_q,
  input logic [NUM_PROCS-1:0] free_q,
  input logic                 sgl_req,
  input logic                 pair_req,
  input logic                 resp_vld,
  input logic                 resp_pair,
  input logic                 resp_ok,
  input logic [IDX_W-1:0]     resp_idx
);
  logic [NUM_PAIRS-1:0] prev_part;
  logic [NUM_PROCS-1:0] prev_free;

  always_ff @(posedge clk) begin
    prev_part <= part_q;
    prev_free <= free_q;
  end

  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    (sgl_req || pair_req) |=> resp_vld); // R2

  AST_IDLE_NO_RESP: assert property (@(posedge clk) disable iff (rst)
    !(sgl_req || pair_req) |=> !resp_vld); // R2

  AST_PAIR_WINS: assert property (@(posedge clk) disable iff (rst)
    pair_req |=> resp_pair); // R7

  AST_PAIR_BASE_EVEN: assert property (@(posedge clk) disable iff (rst)
    (resp_vld && resp_pair && resp_ok) |-> !resp_idx[0]); // R4

  AST_SINGLE_REGION: assert property (@(posedge clk) disable iff (rst)
    (resp_vld && !resp_pair && resp_ok) |-> prev_part[resp_idx[IDX_W-1:1]]); // R3

  AST_PAIR_REGION: assert property (@(posedge clk) disable iff (rst)
    (resp_vld && resp_pair && resp_ok) |-> !prev_part[resp_idx[IDX_W-1:1]]); // R5

  AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (rst)
    (resp_vld && resp_ok) |-> prev_free[resp_idx]); // R10

  AST_PAIR_MATE_FREE: assert property (@(posedge clk) disable iff (rst)
    (resp_vld && resp_pair && resp_ok) |-> prev_free[resp_idx | IDX_W'(1)]); // R5

  AST_FAIL_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
    (resp_vld && !resp_ok) |-> (resp_idx == '0)); // R6
endmodule

bind pair_alloc pair_alloc_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .part_q   (part_q),
  .free_q   (free_q),
  .sgl_req  (sgl_req),
  .pair_req (pair_req),
  .resp_vld (resp_vld),
  .resp_pair(resp_pair),
  .resp_ok  (resp_ok),
  .resp_idx (resp_idx)
);

// File: tb/tb_pair_alloc.sv
module tb_pair_alloc;
  logic       clk = 1'b0;
  logic       rst;
  logic       part_we;
  logic [7:0] part_wdata;
  logic       sgl_req, pair_req, rel_vld, rel_pair;
  logic [3:0] rel_idx;
  logic       resp_vld, resp_pair, resp_ok;
  logic [3:0] resp_idx;

  int checks = 0;
  int fails  = 0;

  logic [15:0] mfree;
  logic [7:0]  mpart;

  always #4ns clk = ~clk;

  pair_alloc dut (
    .clk(clk), .rst(rst), .part_we(part_we), .part_wdata(part_wdata),
    .sgl_req(sgl_req), .pair_req(pair_req), .rel_vld(rel_vld),
    .rel_pair(rel_pair), .rel_idx(rel_idx), .resp_vld(resp_vld),
    .resp_pair(resp_pair), .resp_ok(resp_ok), .resp_idx(resp_idx)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle of stimulus; checks the response against the model state
  // as it was before the clock edge, then advances the model.
  task automatic drive(input bit s, input bit p, input bit rv, input bit rp,
                       input int ri, input bit we, input logic [7:0] wd,
                       input string tag);
    bit          e_ok = 0;
    int          e_idx = 0;
    logic [15:0] take = '0;
    logic [15:0] give = '0;
    if (p) begin
      for (int q = 7; q >= 0; q--)
        if (!mpart[q] && mfree[2*q] && mfree[2*q+1]) begin
          e_ok = 1; e_idx = 2*q;
        end
      if (e_ok) begin take[e_idx] = 1'b1; take[e_idx+1] = 1'b1; end
    end else if (s) begin
      for (int i = 15; i >= 0; i--)
        if (mfree[i] && mpart[i/2]) begin e_ok = 1; e_idx = i; end
      if (e_ok) take[e_idx] = 1'b1;
    end
    if (rv) begin
      if (rp) begin give[(ri/2)*2] = 1'b1; give[(ri/2)*2+1] = 1'b1; end
      else give[ri] = 1'b1;
    end
    sgl_req = s; pair_req = p; rel_vld = rv; rel_pair = rp;
    rel_idx = 4'(ri); part_we = we; part_wdata = wd;
    @(negedge clk);
    if (s || p) begin
      chk(tag, "resp_vld", int'(resp_vld), 1);
      chk(tag, "resp_pair", int'(resp_pair), int'(p));
      chk(tag, "resp_ok", int'(resp_ok), int'(e_ok));
      chk(tag, "resp_idx", int'(resp_idx), e_idx);
    end else begin
      chk(tag, "resp_vld idle", int'(resp_vld), 0);
    end
    mfree = (mfree & ~take) | give;
    if (we) mpart = wd;
    sgl_req = 0; pair_req = 0; rel_vld = 0; rel_pair = 0; part_we = 0;
  endtask

  task automatic release_all();
    for (int q = 0; q < 8; q++) drive(0, 0, 1, 1, 2*q, 0, 8'h00, "R8 release");
  endtask

  initial begin
    #(8ns * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1; part_we = 0; part_wdata = 0; sgl_req = 0; pair_req = 0;
    rel_vld = 0; rel_pair = 0; rel_idx = 0;
    mfree = '1; mpart = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1", "resp_vld in reset", int'(resp_vld), 0);
    rst = 0;

    // R1: reset state seen through the ports
    drive(1, 0, 0, 0, 0, 0, 8'h00, "R1 first single after reset");
    chk("R1", "first grant index", int'(resp_idx), 0);
    drive(0, 1, 0, 0, 0, 0, 8'h00, "R1 R5 pair with all-single partition");
    release_all();

    // R2..R6, R10: sweep every partition, drain with pairs then singles
    for (int pv = 0; pv < 256; pv++) begin
      drive(0, 0, 0, 0, 0, 1, 8'(pv), "R9 partition write");
      for (int k = 0; k < 9; k++) drive(0, 1, 0, 0, 0, 0, 8'h00, "R4 R5 R6 pair sweep");
      for (int k = 0; k < 17; k++) drive(1, 0, 0, 0, 0, 0, 8'h00, "R2 R3 R6 R10 single sweep");
      release_all();
    end

    // R7: both kinds at once, pair wins, single takes nothing
    drive(0, 0, 0, 0, 0, 1, 8'h0F, "R9 partition write");
    drive(1, 1, 0, 0, 0, 0, 8'h00, "R7 simultaneous requests");
    chk("R7", "pair base", int'(resp_idx), 8);
    drive(1, 0, 0, 0, 0, 0, 8'h00, "R7 single after dropped single");
    chk("R7", "single still gets 0", int'(resp_idx), 0);
    release_all();

    // R8: release in the same cycle as a request is not yet visible
    drive(0, 0, 0, 0, 0, 1, 8'hFF, "R9 partition write");
    drive(1, 0, 0, 0, 0, 0, 8'h00, "R8 take 0");
    drive(1, 0, 1, 0, 0, 0, 8'h00, "R8 request with release of 0");
    chk("R8", "same-cycle release hidden", int'(resp_idx), 1);
    drive(1, 0, 0, 0, 0, 0, 8'h00, "R8 released 0 now free");
    chk("R8", "released processor", int'(resp_idx), 0);
    release_all();

    // R9: partition write concurrent with a pair request uses old value
    drive(0, 1, 0, 0, 0, 1, 8'h00, "R9 pair with concurrent write");
    chk("R9", "old partition blocks pair", int'(resp_ok), 0);
    drive(0, 1, 0, 0, 0, 0, 8'h00, "R9 pair after write");
    chk("R9", "new partition allows pair", int'(resp_ok), 1);
    release_all();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule